// File: doc/BRIEF.md
# Full-Control SAR Converter Sequencer

This block runs on the host clock and operates an external 12-bit successive-approximation converter that has a parallel bus. Every control strobe is driven by the block. It makes the converter clock by dividing the host clock. It lowers the active-low start strobe on a falling edge of that converter clock, so every conversion lasts exactly 13 converter clocks. It then waits for the converter's active-low end-of-conversion line to fall, performs a read with select and read both low, and captures the two's-complement result. The result leaves the block on a valid/ready stream.

The converter has several timing minimums, and the block enforces each of them with a counter programmed in host clock cycles:
- the power-up wait before the first start;
- the width of the start pulse;
- the read access time;
- the acquisition gap between the end of one conversion and the next start.

If the stream consumer stalls, the block holds the captured word and starts no further conversion, so no sample is dropped.

Top module: `adc_fullctl_seq`

## Requirements
- R1: While reset is asserted, the three strobes `adc_start_n`, `adc_sel_n` and `adc_rd_n` are high and `res_valid` is low. After reset is released, `adc_start_n` does not fall until more than `PWRUP_CYC` host cycles have passed. Elaboration rejects a `PWRUP_CYC` shorter than 14 converter clocks.
- R2: A conversion is started by pulsing `adc_start_n` low. During the whole low pulse, `adc_sel_n` and `adc_rd_n` stay high.
- R3: A read drives `adc_sel_n` and `adc_rd_n` low together while `adc_start_n` stays high. A read occurs only after `adc_eoc_n` has fallen following the latest start.
- R4: `adc_clk` toggles every `HALF_DIV` host cycles. `adc_start_n` falls in the same host cycle in which `adc_clk` falls. Because `HALF_DIV` must be at least `START_SETUP_CYC`, the start edge comes at least one half period before the next rising edge of `adc_clk`.
- R5: At least `ACQ_CYC` host cycles pass between a falling edge of `adc_eoc_n` and the next falling edge of `adc_start_n`.
- R6: `adc_start_n` stays low for at least `CW_CYC` host cycles.
- R7: `adc_data` is captured no earlier than `RD_CYC` + 1 host cycles after the read strobes go low. `res_data` equals the captured word bit for bit: bit 11 is the sign of a two's-complement value.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` does not change. The word is consumed on the cycle in which both `res_valid` and `res_ready` are high.
- R9: No conversion starts while a captured word is still waiting on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_clk | output | 1 | Divided converter clock |
| adc_start_n | output | 1 | Active-low convert-start strobe |
| adc_sel_n | output | 1 | Active-low chip select |
| adc_rd_n | output | 1 | Active-low read strobe |
| adc_eoc_n | input | 1 | Converter end-of-conversion line, falls when a result is ready |
| adc_data | input | DATA_W | Converter parallel result bus |
| res_valid | output | 1 | Stream word valid |
| res_ready | input | 1 | Stream consumer ready |
| res_data | output | DATA_W | Captured two's-complement result |

## Verification
A behavioural converter in the bench counts 13 rising converter clocks after each start and then lowers its end-of-conversion line. Until the read has been held for the access time, it drives the complement of the true word on the data bus, so a read taken too early shows up as a bit-inverted value.

The sample words include:
- the most negative and most positive codes, zero and minus one, which show sign handling;
- alternating bit patterns, which catch swapped or stuck bit lanes;
- a stride sequence of further values.

The consumer is always ready at first, then stalls for a long stretch, then toggles ready every cycle. The stall shows whether the block holds its word and suspends conversions. The toggling shows whether it loses or repeats a word at the handshake.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_PWRUP = 2'd0,
      ST_WAIT  = 2'd1,
      ST_CONV  = 2'd2,
      ST_READ  = 2'd3
   } seq_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_cnv_clkgen.sv
module adc_cnv_clkgen #(
   parameter int unsigned HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic cnv_clk,
   output logic fall_next
);
   localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic [DW-1:0] cnt;
   logic          wrap;

   assign wrap      = (cnt == DW'(HALF_DIV - 1));
   assign fall_next = wrap && cnv_clk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         cnv_clk <= 1'b0;
      end else if (wrap) begin
         cnt     <= '0;
         cnv_clk <= ~cnv_clk;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R4: the converter clock never holds a level longer than HALF_DIV host cycles
   a_r4_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      fall_next |=> $fell(cnv_clk));

endmodule

// File: rtl/adc_dly_timer.sv
module adc_dly_timer #(
   parameter int unsigned W    = 8,
   parameter int unsigned INIT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   assign done = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= W'(INIT);
      else if (load)
         cnt <= load_val;
      else if (!done)
         cnt <= cnt - 1'b1;
   end

   // R5 R6 R7: a running interval only counts down until it expires
   a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      !load && !done |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);
   logic lvl;
   logic lvl_q;

   if (STAGES == 0) begin : g_direct
      assign lvl = din;
   end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh[0] <= 1'b1;
         else        sh[0] <= din;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) sh[i] <= 1'b1;
            else        sh[i] <= sh[i-1];
         end
      end
      assign lvl = sh[STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b1;
      else        lvl_q <= lvl;
   end

   assign fall = lvl_q && !lvl;

endmodule

// File: rtl/adc_fullctl_seq.sv
module adc_fullctl_seq
   import adc_seq_pkg::*;
#(
   parameter int unsigned DATA_W          = 12,
   parameter int unsigned HALF_DIV        = 2,
   parameter int unsigned START_SETUP_CYC = 1,
   parameter int unsigned PWRUP_CYC       = 120,
   parameter int unsigned ACQ_CYC         = 24,
   parameter int unsigned CW_CYC          = 3,
   parameter int unsigned RD_CYC          = 5,
   parameter int unsigned SYNC_STAGES     = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   output logic                     adc_clk,
   output logic                     adc_start_n,
   output logic                     adc_sel_n,
   output logic                     adc_rd_n,
   input  logic                     adc_eoc_n,
   input  logic [DATA_W-1:0]        adc_data,
   output logic                     res_valid,
   input  logic                     res_ready,
   output logic signed [DATA_W-1:0] res_data
);
   localparam int unsigned TMAX  = max2(max2(PWRUP_CYC, ACQ_CYC), max2(CW_CYC, RD_CYC));
   localparam int unsigned CNT_W = $clog2(TMAX + 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (HALF_DIV < START_SETUP_CYC || HALF_DIV == 0) begin : g_bad_div
      $error("HALF_DIV must cover the start setup time");
   end
   if (PWRUP_CYC < 28 * HALF_DIV) begin : g_bad_pwrup
      $error("PWRUP_CYC shorter than 14 converter clocks");
   end
   if (CW_CYC < 1 || RD_CYC < 1) begin : g_bad_pulse
      $error("CW_CYC and RD_CYC must be at least 1");
   end

   seq_state_e       st;
   logic             fall_next;
   logic             eoc_fall;
   logic             eoc_seen;
   logic             pwr_done;
   logic             acq_done;
   logic             step_done;
   logic             start_go;
   logic             read_go;
   logic             step_load;
   logic [CNT_W-1:0] step_val;

   adc_cnv_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnv_clk   (adc_clk),
      .fall_next (fall_next)
   );

   adc_eoc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (adc_eoc_n),
      .fall  (eoc_fall)
   );

   adc_dly_timer #(.W(CNT_W), .INIT(PWRUP_CYC)) u_pwr_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (1'b0),
      .load_val ('0),
      .done     (pwr_done)
   );

   adc_dly_timer #(.W(CNT_W), .INIT(0)) u_acq_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (eoc_fall),
      .load_val (CNT_W'(ACQ_CYC)),
      .done     (acq_done)
   );

   adc_dly_timer #(.W(CNT_W), .INIT(0)) u_step_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (step_load),
      .load_val (step_val),
      .done     (step_done)
   );

   assign start_go  = (st == ST_WAIT) && !res_valid && acq_done && fall_next;
   assign read_go   = (st == ST_CONV) && adc_start_n && (eoc_seen || eoc_fall);
   assign step_load = start_go || read_go;
   assign step_val  = start_go ? CNT_W'(CW_CYC) : CNT_W'(RD_CYC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_PWRUP;
         adc_start_n <= 1'b1;
         adc_sel_n   <= 1'b1;
         adc_rd_n    <= 1'b1;
         eoc_seen    <= 1'b0;
         res_valid   <= 1'b0;
         res_data    <= '0;
      end else begin
         if (res_valid && res_ready) res_valid <= 1'b0;
         unique case (st)
            ST_PWRUP: if (pwr_done) st <= ST_WAIT;
            ST_WAIT: begin
               if (start_go) begin
                  adc_start_n <= 1'b0;
                  eoc_seen    <= 1'b0;
                  st          <= ST_CONV;
               end
            end
            ST_CONV: begin
               if (step_done) adc_start_n <= 1'b1;
               if (eoc_fall)  eoc_seen    <= 1'b1;
               if (read_go) begin
                  adc_sel_n <= 1'b0;
                  adc_rd_n  <= 1'b0;
                  st        <= ST_READ;
               end
            end
            ST_READ: begin
               if (step_done) begin
                  res_data  <= adc_data;
                  res_valid <= 1'b1;
                  adc_sel_n <= 1'b1;
                  adc_rd_n  <= 1'b1;
                  st        <= ST_WAIT;
               end
            end
            default: st <= ST_PWRUP;
         endcase
      end
   end

   a_r2_start_alone: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_start_n |-> adc_sel_n && adc_rd_n);

   a_r3_read_alone: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_rd_n |-> adc_start_n && !adc_sel_n);

   a_r4_start_on_clk_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_start_n) |-> $fell(adc_clk));

   a_r7_capture_from_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_valid) |-> $past(!adc_rd_n));

   a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_ready |=> res_valid && $stable(res_data));

   a_r9_no_start_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !$fell(adc_start_n));

endmodule

// File: tb/adc_fullctl_seq_tb.sv
module adc_fullctl_seq_tb;
   localparam int unsigned DW       = 12;
   localparam int unsigned HALF_DIV = 2;
   localparam int unsigned PWRUP    = 120;
   localparam int unsigned ACQ      = 24;
   localparam int unsigned CW       = 3;
   localparam int unsigned RD       = 5;
   localparam int          NSAMP    = 16;
   localparam int          WD_LIMIT = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic adc_clk, adc_start_n, adc_sel_n, adc_rd_n;
   logic adc_eoc_n;
   logic [DW-1:0] adc_data;
   logic res_valid;
   logic res_ready = 1'b1;
   logic signed [DW-1:0] res_data;

   always #2 clk = ~clk;   // 250 MHz

   adc_fullctl_seq #(
      .DATA_W(DW), .HALF_DIV(HALF_DIV), .START_SETUP_CYC(1), .PWRUP_CYC(PWRUP),
      .ACQ_CYC(ACQ), .CW_CYC(CW), .RD_CYC(RD), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .adc_clk(adc_clk), .adc_start_n(adc_start_n),
      .adc_sel_n(adc_sel_n), .adc_rd_n(adc_rd_n), .adc_eoc_n(adc_eoc_n),
      .adc_data(adc_data), .res_valid(res_valid), .res_ready(res_ready),
      .res_data(res_data)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural converter ----------------
   logic [DW-1:0] src_q[$];
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] m_result = '0;
   logic m_busy = 1'b0;
   logic m_pclk = 1'b0;
   logic m_pstart = 1'b1;
   int   m_edges = 0;
   int   m_rdcnt = 0;
   logic m_eoc = 1'b1;

   assign adc_eoc_n = m_eoc;
   assign adc_data  = (m_rdcnt >= RD) ? m_result : ~m_result;

   always @(posedge clk) begin
      m_pclk   <= adc_clk;
      m_pstart <= adc_start_n;
      if (!rst_n) begin
         m_busy  <= 1'b0;
         m_eoc   <= 1'b1;
         m_rdcnt <= 0;
      end else begin
         if (!adc_start_n && m_pstart && !m_busy) begin
            m_busy  <= 1'b1;
            m_edges <= 0;
         end else if (m_busy && adc_clk && !m_pclk) begin
            m_edges <= m_edges + 1;
            if (m_edges == 12) begin
               m_busy   <= 1'b0;
               m_eoc    <= 1'b0;
               m_result <= (src_q.size() > 0) ? src_q.pop_front() : '0;
            end
         end
         if (!adc_sel_n && !adc_rd_n) begin
            m_rdcnt <= m_rdcnt + 1;
            m_eoc   <= 1'b1;
         end else begin
            m_rdcnt <= 0;
         end
      end
   end

   // ---------------- per-clock protocol reference ----------------
   int   cyc = 0;
   int   received = 0;
   int   eoc_cyc = -1;
   int   low_cnt = 0;
   bit   eoc_since_start = 1'b0;
   logic p_start = 1'b1, p_clk = 1'b0, p_eoc = 1'b1, p_rd = 1'b1;
   logic p_valid = 1'b0, p_ready = 1'b1;
   logic [DW-1:0] p_data = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (p_start && !adc_start_n) begin
            chk(cyc > PWRUP, "R1", "start cycle after reset", cyc, PWRUP + 1);
            chk(p_clk && !adc_clk, "R4", "adc_clk falling with start", adc_clk, 0);
            if (eoc_cyc >= 0)
               chk(cyc - eoc_cyc >= ACQ, "R5", "acquisition gap", cyc - eoc_cyc, ACQ);
            chk(!p_valid, "R9", "word pending at start", p_valid, 0);
            low_cnt = 0;
            eoc_since_start = 1'b0;
         end
         if (!adc_start_n) begin
            low_cnt++;
            chk(adc_sel_n && adc_rd_n, "R2", "select/read during start", adc_rd_n, 1);
         end
         if (!p_start && adc_start_n)
            chk(low_cnt >= CW, "R6", "start pulse width", low_cnt, CW);
         if (p_eoc && !adc_eoc_n) begin
            eoc_cyc = cyc;
            eoc_since_start = 1'b1;
         end
         if (!adc_rd_n)
            chk(adc_start_n && !adc_sel_n, "R3", "strobes during read", adc_start_n, 1);
         if (p_rd && !adc_rd_n)
            chk(eoc_since_start, "R3", "read after end of conversion", eoc_since_start, 1);
         if (p_valid && !p_ready)
            chk(res_valid && res_data == p_data, "R8", "held word",
                int'(res_data), int'(p_data));
         if (res_valid && res_ready) begin
            logic [DW-1:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
            chk(res_data == e, "R7", "result word", int'(res_data), int'(e));
            received++;
         end
      end
      p_start = adc_start_n; p_clk = adc_clk; p_eoc = adc_eoc_n; p_rd = adc_rd_n;
      p_valid = res_valid;   p_ready = res_ready; p_data = res_data;
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int i = 0; i < NSAMP; i++) begin
         logic [DW-1:0] v;
         case (i)
            0: v = 12'h800;
            1: v = 12'h7FF;
            2: v = 12'h000;
            3: v = 12'hFFF;
            4: v = 12'h555;
            5: v = 12'hAAA;
            default: v = DW'((i * 667 + 19) % 4096);
         endcase
         src_q.push_back(v);
         exp_q.push_back(v);
      end
      repeat (5) @(negedge clk);
      chk(adc_start_n && adc_sel_n && adc_rd_n, "R1", "strobes in reset",
          {adc_start_n, adc_sel_n, adc_rd_n}, 7);
      chk(!res_valid, "R1", "valid in reset", res_valid, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      while (received < 4 && cyc < WD_LIMIT) @(negedge clk);
      @(posedge clk); #1 res_ready = 1'b0;
      repeat (400) @(posedge clk);
      chk(received == 4, "R9", "words delivered during stall", received, 4);
      #1 res_ready = 1'b1;
      while (received < 8 && cyc < WD_LIMIT) @(negedge clk);
      while (received < NSAMP && cyc < WD_LIMIT) begin
         @(posedge clk); #1 res_ready = ~res_ready;
      end
      if (cyc >= WD_LIMIT) chk(1'b0, "R7", "watchdog expired, words", received, NSAMP);
      chk(received == NSAMP, "R7", "words received", received, NSAMP);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule